// File: doc/BRIEF.md
# Dual-Edge Frame-Aligned Serial Word Receiver

This block receives one serial lane that carries 12-bit words. A data bit arrives on every rising edge and on every falling edge of a bit clock that runs at six times the word rate. A second clock, the frame clock, runs at the word rate. The block finds word boundaries from the rising transitions of the frame clock and rebuilds each word with the first bit received as the least significant bit. The result is presented on a parallel output with a one-cycle valid strobe. All outputs are in the bit-clock domain.

A two-stage front end does the capture. A rising-edge register takes the even bits and samples the frame clock. A falling-edge register takes the odd bits. Each bit-clock cycle therefore hands one rise/fall pair to an assembler state machine, which has three states:
- `ST_HUNT`: waiting for a boundary.
- `ST_FILL`: collecting the six pairs of a word.
- `ST_ARMED`: a word has just been issued and the next pair must open a new frame.

The transitions are:
- HUNT→FILL on a boundary.
- FILL→FILL for each further pair. A boundary that arrives while in FILL causes a restart.
- FILL→ARMED when the sixth pair completes the word.
- ARMED→FILL when the expected boundary arrives.
- ARMED→HUNT when the boundary is missing (overrun).
- HUNT→HUNT while no boundary is seen.

Top module: `ddr_frame_deser`

## Requirements
- R1: Within a word, bit 2i is the bit sampled on the rising edge of the i-th bit-clock cycle of the frame, and bit 2i+1 is the bit sampled on the falling edge that follows it. Bit 0 is the first bit received.
- R2: A word holds 12 bits, taken over 6 bit-clock cycles. Two consecutive valid strobes are at least 6 bit-clock cycles apart.
- R3: A frame boundary is a bit-clock rising edge at which the frame clock is sampled high after it was sampled low at the previous rising edge. A frame clock that is already high when reset is released does not mark a boundary.
- R4: `word_vld` is high for exactly one bit-clock cycle. It rises on the bit-clock rising edge that follows the falling-edge capture of bit 11.
- R5: After reset, `word_vld` stays low until a boundary has been seen and 12 bits have been collected after it.
- R6: When a boundary arrives before 12 bits have been collected, the partial word is discarded and no strobe is issued. Collection restarts with the pair that carries the new boundary.
- R7: When the pair that follows a finished word is not a boundary, the block returns to hunting. No strobe is issued until a new boundary and 12 further bits.
- R8: While reset (`rst_n` low) is asserted, `word_out` is 0 and `word_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Bit clock at six times the word rate; both edges carry data |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_din | input | 1 | Serial data, one bit per bit-clock edge |
| frm_clk | input | 1 | Frame clock at the word rate; its rising transition opens a word |
| word_out | output | 12 | Rebuilt word, LSB first received |
| word_vld | output | 1 | One-cycle strobe marking a new word on word_out |

## Verification
The assertions take for granted that the serial data meets setup and hold at both bit-clock edges. They also assume the frame clock changes only between rising bit-clock edges, so that each rising edge sees one clean frame-clock level. The stimulus respects this by changing the serial data a quarter period before the edge that samples it, and by changing the frame clock only in the low phase of the bit clock. Frames of 6 pairs, short frames of 2 and 4 pairs, and an overlong frame of 8 pairs are all built with the frame clock high for the first half of their pairs. Every one of them therefore starts with a true boundary.

// File: rtl/deser_pkg.sv
package deser_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_FILL  = 2'd1,
        ST_ARMED = 2'd2
    } asm_state_t;
endpackage

// File: rtl/ddr_sampler.sv
module ddr_sampler (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic ser_din,
    input  logic frm_clk,
    output logic rise_bit,
    output logic fall_bit,
    output logic frame_start
);
    logic rise_q;
    logic fall_q;
    logic frm_q;
    logic frm_prev;

    // Rising edge: even bit and frame-clock level.
    // Frame history resets high so a frame clock already high is no boundary.
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q   <= 1'b0;
            frm_q    <= 1'b1;
            frm_prev <= 1'b1;
        end else begin
            rise_q   <= ser_din;
            frm_q    <= frm_clk;
            frm_prev <= frm_q;
        end
    end

    // Falling edge: odd bit
    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= ser_din;
    end

    assign rise_bit    = rise_q;
    assign fall_bit    = fall_q;
    assign frame_start = frm_q & ~frm_prev;
endmodule

// File: rtl/word_builder.sv
module word_builder
    import deser_pkg::*;
#(
    parameter int PAIRS = 6
) (
    input  logic                 bit_clk,
    input  logic                 rst_n,
    input  logic                 rise_bit,
    input  logic                 fall_bit,
    input  logic                 frame_start,
    output logic [2*PAIRS-1:0]   word_out,
    output logic                 word_vld
);
    localparam int WORD_W = 2 * PAIRS;
    localparam int CNT_W  = (PAIRS > 2) ? $clog2(PAIRS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PAIRS - 1);

    asm_state_t        state, state_nxt;
    logic [CNT_W-1:0]  cnt, cnt_nxt, wr_idx;
    logic              wr_en, emit;
    logic [PAIRS-1:0]  rise_acc, fall_acc, rise_nxt, fall_nxt;
    logic [WORD_W-1:0] word_nxt, word_q;
    logic              vld_q;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        wr_idx    = cnt;
        wr_en     = 1'b0;
        emit      = 1'b0;
        unique case (state)
            ST_HUNT: begin
                if (frame_start) begin
                    state_nxt = ST_FILL;
                    wr_idx    = '0;
                    wr_en     = 1'b1;
                    cnt_nxt   = CNT_W'(1);
                end
            end
            ST_FILL: begin
                wr_en = 1'b1;
                if (frame_start) begin
                    wr_idx  = '0;
                    cnt_nxt = CNT_W'(1);
                end else if (cnt == LAST) begin
                    emit      = 1'b1;
                    state_nxt = ST_ARMED;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + CNT_W'(1);
                end
            end
            ST_ARMED: begin
                if (frame_start) begin
                    state_nxt = ST_FILL;
                    wr_idx    = '0;
                    wr_en     = 1'b1;
                    cnt_nxt   = CNT_W'(1);
                end else begin
                    state_nxt = ST_HUNT;
                end
            end
            default: state_nxt = ST_HUNT;
        endcase
    end

    always_comb begin
        rise_nxt = rise_acc;
        fall_nxt = fall_acc;
        for (int i = 0; i < PAIRS; i++) begin
            if (wr_en && wr_idx == CNT_W'(i)) begin
                rise_nxt[i] = rise_bit;
                fall_nxt[i] = fall_bit;
            end
        end
    end

    for (genvar g = 0; g < PAIRS; g++) begin : g_interleave
        assign word_nxt[2*g]   = rise_nxt[g];
        assign word_nxt[2*g+1] = fall_nxt[g];
    end

    // State register process
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_HUNT;
            cnt      <= '0;
            rise_acc <= '0;
            fall_acc <= '0;
        end else begin
            state    <= state_nxt;
            cnt      <= cnt_nxt;
            rise_acc <= rise_nxt;
            fall_acc <= fall_nxt;
        end
    end

    // Output process
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= emit;
            if (emit) word_q <= word_nxt;
        end
    end

    assign word_out = word_q;
    assign word_vld = vld_q;

    // Spacing tracker for the strobe-distance check
    logic [CNT_W:0] gap_cnt;
    logic           seen_vld;
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt  <= '0;
            seen_vld <= 1'b0;
        end else if (vld_q) begin
            gap_cnt  <= '0;
            seen_vld <= 1'b1;
        end else if (gap_cnt < (CNT_W+1)'(PAIRS)) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // R4
    vld_pulse_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        vld_q |=> !vld_q);

    // R2
    vld_spacing_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (vld_q && seen_vld) |-> (gap_cnt >= (CNT_W+1)'(PAIRS - 1)));

    // R6
    short_frame_drop_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (frame_start && state == ST_FILL) |=> (!vld_q && state == ST_FILL));

    // R7
    overrun_hunt_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (state == ST_ARMED && !frame_start) |=> (state == ST_HUNT && !vld_q));

    // R5
    hunt_hold_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (state == ST_HUNT && !frame_start) |=> (state == ST_HUNT && !vld_q));
endmodule

// File: rtl/ddr_frame_deser.sv
module ddr_frame_deser #(
    parameter int PAIRS  = 6,
    parameter int WORD_W = 2 * PAIRS
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              ser_din,
    input  logic              frm_clk,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld
);
    logic rise_bit;
    logic fall_bit;
    logic frame_start;

    ddr_sampler u_sampler (
        .bit_clk     (bit_clk),
        .rst_n       (rst_n),
        .ser_din     (ser_din),
        .frm_clk     (frm_clk),
        .rise_bit    (rise_bit),
        .fall_bit    (fall_bit),
        .frame_start (frame_start)
    );

    word_builder #(.PAIRS(PAIRS)) u_builder (
        .bit_clk     (bit_clk),
        .rst_n       (rst_n),
        .rise_bit    (rise_bit),
        .fall_bit    (fall_bit),
        .frame_start (frame_start),
        .word_out    (word_out),
        .word_vld    (word_vld)
    );
endmodule

// File: tb/ddr_frame_deser_test.sv
`timescale 1ns/1ps
module ddr_frame_deser_test;
    logic        bit_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic        ser_din = 1'b0;
    logic        frm_clk = 1'b1;
    logic [11:0] word_out;
    logic        word_vld;

    int checks = 0;
    int errors = 0;
    int vld_seen = 0;
    bit prev_vld = 1'b0;
    bit finished = 1'b0;
    logic [11:0] exp_q[$];

    always #2.5 bit_clk = ~bit_clk;

    ddr_frame_deser uut (
        .bit_clk  (bit_clk),
        .rst_n    (rst_n),
        .ser_din  (ser_din),
        .frm_clk  (frm_clk),
        .word_out (word_out),
        .word_vld (word_vld)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bit-clock cycle: rise bit, then fall bit; frame clock set in low phase
    task automatic send_pair(input bit r, input bit f, input bit fc);
        @(negedge bit_clk);
        #1.25;
        ser_din = r;
        frm_clk = fc;
        @(posedge bit_clk);
        #1.25;
        ser_din = f;
    endtask

    // Driver: frame of npairs, frame clock high for the first half
    task automatic send_frame(input logic [11:0] w, input int npairs, input bit expect_v);
        if (expect_v) exp_q.push_back(w);
        for (int i = 0; i < npairs; i++) begin
            send_pair((i < 6) ? w[2*i] : 1'b0, (i < 6) ? w[2*i+1] : 1'b0,
                      (i < (npairs + 1) / 2) ? 1'b1 : 1'b0);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send_pair(1'b0, 1'b0, 1'b0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(posedge bit_clk);
            #1.25;
            if (rst_n) begin
                if (word_vld) begin
                    vld_seen++;
                    // R4: strobe is a single cycle
                    chk(!prev_vld, "R4 strobe longer than one cycle", 1, 0);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R5 R6 R7 unexpected strobe", int'(word_out), 0);
                    end else begin
                        logic [11:0] e;
                        e = exp_q.pop_front();
                        // R1 R2: bit order and width of the rebuilt word
                        chk(word_out == e, "R1 R2 word value", int'(word_out), int'(e));
                    end
                end
                prev_vld = word_vld;
            end
        end
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        int base;
        #1;
        // R8: reset values
        chk(word_vld == 1'b0, "R8 word_vld in reset", int'(word_vld), 0);
        chk(word_out == 12'h0, "R8 word_out in reset", int'(word_out), 0);
        repeat (3) @(posedge bit_clk);
        #1.25;
        chk(word_vld == 1'b0 && word_out == 12'h0, "R8 outputs held in reset", int'(word_out), 0);
        rst_n = 1'b1;

        // R3 R5: frame clock high at reset release is no boundary
        send_pair(1'b1, 1'b1, 1'b1);
        send_pair(1'b1, 1'b1, 1'b1);
        idle(3);
        chk(vld_seen == 0, "R3 R5 no strobe before boundary", vld_seen, 0);

        // R1 R2: back-to-back full frames
        send_frame(12'hA5C, 6, 1'b1);
        send_frame(12'h001, 6, 1'b1);
        send_frame(12'h800, 6, 1'b1);
        send_frame(12'hFFF, 6, 1'b1);
        send_frame(12'h3C6, 6, 1'b1);
        idle(3);
        chk(vld_seen == 5, "R1 R2 strobe count full frames", vld_seen, 5);

        // R6: short frames discarded, restart on new boundary
        base = vld_seen;
        send_frame(12'hFFF, 4, 1'b0);
        send_frame(12'hFFF, 2, 1'b0);
        chk(vld_seen == base, "R6 no strobe for short frames", vld_seen, base);
        send_frame(12'h5A3, 6, 1'b1);
        idle(3);
        chk(vld_seen == base + 1, "R6 frame after short frames", vld_seen, base + 1);

        // R7: overlong frame, then missing boundary, then recovery
        base = vld_seen;
        send_frame(12'h7E1, 8, 1'b1);
        send_frame(12'h18B, 6, 1'b1);
        idle(3);
        chk(vld_seen == base + 2, "R7 strobes around overrun", vld_seen, base + 2);

        // R6 at hunt: short frame right after idle, then a full one
        base = vld_seen;
        send_frame(12'hABC, 2, 1'b0);
        send_frame(12'h924, 6, 1'b1);
        idle(3);
        chk(vld_seen == base + 1, "R6 restart from idle", vld_seen, base + 1);

        chk(exp_q.size() == 0, "R2 words still pending", exp_q.size(), 0);
        summary();
    end
endmodule